// File: doc/BRIEF.md
# Barrel-Core Thread Issue Scheduler

This block decides, on every clock, which hardware thread of a fine-grain multithreaded core may issue an instruction into the shared in-order pipeline. It has three policies, chosen by a two-bit select. The first is a fixed rotation that gives each thread one turn in strict order. The second is a programmable table of issue slots, each naming a thread, that is walked in order. The third is a ready-driven round-robin pick. In the two slot-owning policies, a cycle whose owner is not ready becomes an empty pipeline slot. The slot is never handed to another thread.

Each decision enters a tag pipeline that runs beside the instruction pipeline. The tag is a valid bit plus a thread identifier. Each pipeline stage can read the tag at its depth and so select the right thread's state. With four threads rotating through a five-stage pipeline that has no bypass network, a thread's older instruction has left write-back before its next instruction reaches register read.

Top module: `thread_slot_sched`

## Requirements
- R1: Reset clears every tag stage to invalid with identifier 0. The rotation points at thread 0, the table walk points at slot 0, and table slot i names thread i mod N. The first ready-priority scan after reset starts at thread 0.
- R2: Policy code 0 is fixed rotation. The owner of each cycle is thread 0, 1, ..., N-1 in turn, advancing by one every clock, so each thread gets exactly one opportunity in every N cycles.
- R3: In fixed-rotation or table policy, when the owner's ready bit is low, issue_valid is 0, bubble is 1 and issue_tid is 0. No other thread issues in that cycle. In every policy, bubble is the inverse of issue_valid.
- R4: Policy code 1 is slot-table mode. The walk steps through slots 0..S-1 in order, one per clock, and the cycle's owner is the thread named by the current slot.
- R5: A table write (tbl_wr_en with slot index and thread ID) becomes visible only when the walk next moves from slot S-1 to slot 0. A write made while slot S-1 is in use applies to the slot 0 that follows it. A pass in progress always keeps its old contents.
- R6: Policy code 2 is ready-priority. The issuing thread is the first ready thread found by scanning upward, with wrap-around, from the thread after the last one issued in this mode. If no thread is ready, the cycle is a bubble.
- R7: The tag pipeline has PIPE_DEPTH stages. Stage 0 holds the previous cycle's issue_valid and issue_tid. Stage k+1 holds what stage k held one clock earlier. Stage k occupies bits [k*TID_W +: TID_W] of tag_tid and bit k of tag_valid.
- R8: After PIPE_DEPTH consecutive cycles of fixed rotation, no two valid tags that are fewer than N stages apart carry the same thread ID.
- R9: Policy code 3 behaves exactly like code 0. The rotation and the table walk advance every clock in every policy, so switching policy never restarts them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_ready | input | N_THREADS | Per-thread ready flags |
| policy | input | 2 | 0 fixed, 1 table, 2 ready-priority, 3 fixed |
| tbl_wr_en | input | 1 | Slot-table write strobe |
| tbl_wr_slot | input | log2(N_SLOTS) | Slot being written |
| tbl_wr_tid | input | log2(N_THREADS) | Thread ID written into the slot |
| issue_valid | output | 1 | A thread issues this cycle |
| issue_tid | output | log2(N_THREADS) | Issuing thread (0 on a bubble) |
| bubble | output | 1 | This cycle's issue slot is empty |
| tag_valid | output | PIPE_DEPTH | Valid bit of each tag stage |
| tag_tid | output | PIPE_DEPTH*log2(N_THREADS) | Thread ID of each tag stage, stage 0 in the low bits |

## Verification
The bench builds the block with its defaults: four threads, eight slots and five tag stages. With eight slots against four threads, the table wrap falls on a rotation boundary, and each table pass covers every default owner twice. That lets writes be placed in the middle of a pass and on its last slot. Five stages is one more than the thread count, so the same-thread spacing rule is visible inside the tag pipeline rather than only off its end. A behavioural model runs alongside the block and is compared on every clock.

// File: rtl/thread_sched_pkg.sv
package thread_sched_pkg;

  typedef enum logic [1:0] {
    POL_FIXED = 2'd0,
    POL_TABLE = 2'd1,
    POL_READY = 2'd2,
    POL_ALIAS = 2'd3
  } sched_policy_e;

  // Modular increment used by every wrapping counter in the block.
  function automatic int unsigned step_mod(int unsigned value, int unsigned limit);
    return (value + 1 >= limit) ? 0 : value + 1;
  endfunction

  // Candidate position k places after a base thread, wrapped to the thread count.
  function automatic int unsigned offset_mod(int unsigned base, int unsigned k,
                                             int unsigned limit);
    return (base + k) % limit;
  endfunction

endpackage

// File: rtl/thread_rotor.sv
module thread_rotor
  import thread_sched_pkg::*;
#(
  parameter int N_THREADS = 4,
  parameter int N_SLOTS   = 8,
  localparam int TID_W    = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
  localparam int SLOT_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [TID_W-1:0]  rot_tid,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              slot_last
);

  // Both walks are free running so a policy change never restarts them.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rot_tid  <= '0;
      slot_idx <= '0;
    end else begin
      rot_tid  <= TID_W'(step_mod(int'(rot_tid), N_THREADS));
      slot_idx <= SLOT_W'(step_mod(int'(slot_idx), N_SLOTS));
    end
  end

  assign slot_last = (int'(slot_idx) == N_SLOTS - 1);

endmodule

// File: rtl/slot_table.sv
module slot_table #(
  parameter int N_THREADS = 4,
  parameter int N_SLOTS   = 8,
  localparam int TID_W    = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
  localparam int SLOT_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [TID_W-1:0]  wr_tid,
  input  logic              commit,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [TID_W-1:0]  rd_tid
);

  logic [TID_W-1:0] pending [N_SLOTS];
  logic [TID_W-1:0] live    [N_SLOTS];

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_entry
    logic [TID_W-1:0] pending_nxt;

    // A write in the commit cycle is forwarded into the new live copy.
    assign pending_nxt = (wr_en && wr_slot == SLOT_W'(g)) ? wr_tid : pending[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pending[g] <= TID_W'(g % N_THREADS);
        live[g]    <= TID_W'(g % N_THREADS);
      end else begin
        pending[g] <= pending_nxt;
        if (commit) live[g] <= pending_nxt;
      end
    end
  end

  assign rd_tid = live[rd_slot];

endmodule

// File: rtl/ready_picker.sv
module ready_picker
  import thread_sched_pkg::*;
#(
  parameter int N_THREADS = 4,
  localparam int TID_W    = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic [N_THREADS-1:0] ready,
  input  logic [TID_W-1:0]     last_tid,
  output logic                 found,
  output logic [TID_W-1:0]     pick
);

  logic [TID_W-1:0] cand;

  // Scan starts one past the last issued thread and wraps back to it.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    cand  = '0;
    for (int k = 1; k <= N_THREADS; k++) begin
      cand = TID_W'(offset_mod(int'(last_tid), k, N_THREADS));
      if (!found && ready[cand]) begin
        found = 1'b1;
        pick  = cand;
      end
    end
  end

endmodule

// File: rtl/tag_pipe.sv
module tag_pipe #(
  parameter int PIPE_DEPTH = 5,
  parameter int TID_W      = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [TID_W-1:0]            in_tid,
  output logic [PIPE_DEPTH-1:0]       valid_q,
  output logic [PIPE_DEPTH*TID_W-1:0] tid_q
);

  for (genvar s = 0; s < PIPE_DEPTH; s++) begin : g_stage
    logic             src_valid;
    logic [TID_W-1:0] src_tid;

    if (s == 0) begin : g_head
      assign src_valid = in_valid;
      assign src_tid   = in_tid;
    end else begin : g_body
      assign src_valid = valid_q[s-1];
      assign src_tid   = tid_q[(s-1)*TID_W +: TID_W];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[s]               <= 1'b0;
        tid_q[s*TID_W +: TID_W]  <= '0;
      end else begin
        valid_q[s]               <= src_valid;
        tid_q[s*TID_W +: TID_W]  <= src_tid;
      end
    end
  end

endmodule

// File: rtl/thread_slot_sched.sv
module thread_slot_sched
  import thread_sched_pkg::*;
#(
  parameter int N_THREADS  = 4,
  parameter int N_SLOTS    = 8,
  parameter int PIPE_DEPTH = 5,
  localparam int TID_W     = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
  localparam int SLOT_W    = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_THREADS-1:0]        thr_ready,
  input  logic [1:0]                  policy,
  input  logic                        tbl_wr_en,
  input  logic [SLOT_W-1:0]           tbl_wr_slot,
  input  logic [TID_W-1:0]            tbl_wr_tid,
  output logic                        issue_valid,
  output logic [TID_W-1:0]            issue_tid,
  output logic                        bubble,
  output logic [PIPE_DEPTH-1:0]       tag_valid,
  output logic [PIPE_DEPTH*TID_W-1:0] tag_tid
);

  sched_policy_e     pol;
  logic [TID_W-1:0]  rot_tid;
  logic [SLOT_W-1:0] slot_idx;
  logic              slot_last;
  logic [TID_W-1:0]  table_tid;
  logic [TID_W-1:0]  sel_owner;
  logic [TID_W-1:0]  last_tid;
  logic              pick_found;
  logic [TID_W-1:0]  pick_tid;
  logic [TID_W-1:0]  cand_tid;

  assign pol = sched_policy_e'(policy);

  thread_rotor #(.N_THREADS(N_THREADS), .N_SLOTS(N_SLOTS)) u_rotor (
    .clk       (clk),
    .rst_n     (rst_n),
    .rot_tid   (rot_tid),
    .slot_idx  (slot_idx),
    .slot_last (slot_last)
  );

  slot_table #(.N_THREADS(N_THREADS), .N_SLOTS(N_SLOTS)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_wr_en),
    .wr_slot (tbl_wr_slot),
    .wr_tid  (tbl_wr_tid),
    .commit  (slot_last),
    .rd_slot (slot_idx),
    .rd_tid  (table_tid)
  );

  ready_picker #(.N_THREADS(N_THREADS)) u_picker (
    .ready    (thr_ready),
    .last_tid (last_tid),
    .found    (pick_found),
    .pick     (pick_tid)
  );

  // Slot owner for the two owner-based policies.
  assign sel_owner = (pol == POL_TABLE) ? table_tid : rot_tid;

  always_comb begin
    if (pol == POL_READY) begin
      issue_valid = pick_found;
      cand_tid    = pick_tid;
    end else begin
      issue_valid = thr_ready[sel_owner];
      cand_tid    = sel_owner;
    end
    issue_tid = issue_valid ? cand_tid : '0;
    bubble    = !issue_valid;
  end

  // Round-robin memory for the ready-priority policy only.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_tid <= TID_W'(N_THREADS - 1);
    end else if (pol == POL_READY && issue_valid) begin
      last_tid <= issue_tid;
    end
  end

  tag_pipe #(.PIPE_DEPTH(PIPE_DEPTH), .TID_W(TID_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (issue_valid),
    .in_tid   (issue_tid),
    .valid_q  (tag_valid),
    .tid_q    (tag_tid)
  );

endmodule

// File: rtl/thread_slot_sched_chk.sv
module thread_slot_sched_chk #(
  parameter int N_THREADS  = 4,
  parameter int N_SLOTS    = 8,
  parameter int PIPE_DEPTH = 5,
  localparam int TID_W     = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
  localparam int RUN_W     = $clog2(PIPE_DEPTH + 1) + 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [N_THREADS-1:0]        thr_ready,
  input logic [1:0]                  policy,
  input logic                        issue_valid,
  input logic [TID_W-1:0]            issue_tid,
  input logic                        bubble,
  input logic [PIPE_DEPTH-1:0]       tag_valid,
  input logic [PIPE_DEPTH*TID_W-1:0] tag_tid,
  input logic [TID_W-1:0]            rot_tid,
  input logic [TID_W-1:0]            sel_owner
);

  logic             past_ok;
  logic [RUN_W-1:0] fix_run;
  logic             fixed_like;
  logic             spacing_clash;

  assign fixed_like = (policy == 2'd0) || (policy == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      fix_run <= '0;
    end else begin
      past_ok <= 1'b1;
      if (!fixed_like)                  fix_run <= '0;
      else if (int'(fix_run) < PIPE_DEPTH) fix_run <= fix_run + 1'b1;
    end
  end

  always_comb begin
    spacing_clash = 1'b0;
    for (int i = 0; i < PIPE_DEPTH; i++) begin
      for (int j = i + 1; j < PIPE_DEPTH; j++) begin
        if (j - i < N_THREADS && tag_valid[i] && tag_valid[j] &&
            tag_tid[i*TID_W +: TID_W] == tag_tid[j*TID_W +: TID_W])
          spacing_clash = 1'b1;
      end
    end
  end

  assert_rotation_R2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> int'(rot_tid) == (int'($past(rot_tid)) + 1) % N_THREADS);

  assert_fixed_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed_like && issue_valid) |-> issue_tid == rot_tid);

  assert_owner_bubble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (policy != 2'd2 && !thr_ready[sel_owner]) |-> (!issue_valid && bubble && issue_tid == '0));

  assert_bubble_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bubble != issue_valid);

  assert_table_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == 2'd1 && issue_valid) |-> issue_tid == sel_owner);

  assert_ready_pick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == 2'd2 && thr_ready != '0) |-> (issue_valid && thr_ready[issue_tid]));

  assert_ready_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_ready == '0) |-> !issue_valid);

  assert_tag_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (tag_valid[0] == $past(issue_valid) &&
                 tag_tid[TID_W-1:0] == $past(issue_tid)));

  for (genvar s = 1; s < PIPE_DEPTH; s++) begin : g_shift
    assert_tag_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (tag_valid[s] == $past(tag_valid[s-1]) &&
                   tag_tid[s*TID_W +: TID_W] == $past(tag_tid[(s-1)*TID_W +: TID_W])));
  end

  assert_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fix_run) >= PIPE_DEPTH) |-> !spacing_clash);

endmodule

bind thread_slot_sched thread_slot_sched_chk #(
  .N_THREADS (N_THREADS),
  .N_SLOTS   (N_SLOTS),
  .PIPE_DEPTH(PIPE_DEPTH)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .thr_ready   (thr_ready),
  .policy      (policy),
  .issue_valid (issue_valid),
  .issue_tid   (issue_tid),
  .bubble      (bubble),
  .tag_valid   (tag_valid),
  .tag_tid     (tag_tid),
  .rot_tid     (rot_tid),
  .sel_owner   (sel_owner)
);

// File: tb/thread_slot_sched_test.sv
module thread_slot_sched_test;

  localparam int NT = 4;
  localparam int NS = 8;
  localparam int ND = 5;
  localparam int TW = 2;
  localparam int SW = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NT-1:0]     thr_ready = '1;
  logic [1:0]        policy = 2'd0;
  logic              tbl_wr_en = 1'b0;
  logic [SW-1:0]     tbl_wr_slot = '0;
  logic [TW-1:0]     tbl_wr_tid = '0;
  logic              issue_valid;
  logic [TW-1:0]     issue_tid;
  logic              bubble;
  logic [ND-1:0]     tag_valid;
  logic [ND*TW-1:0]  tag_tid;

  always #10 clk = ~clk;  // 50 MHz

  thread_slot_sched #(.N_THREADS(NT), .N_SLOTS(NS), .PIPE_DEPTH(ND)) uut (
    .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready), .policy(policy),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_slot(tbl_wr_slot), .tbl_wr_tid(tbl_wr_tid),
    .issue_valid(issue_valid), .issue_tid(issue_tid), .bubble(bubble),
    .tag_valid(tag_valid), .tag_tid(tag_tid)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural model state.
  int m_rot, m_slot, m_last, m_fixrun;
  int m_live[NS];
  int m_pend[NS];
  int m_tv[ND];
  int m_tt[ND];
  int want_tid = -1;
  string want_req = "";
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_rot = 0; m_slot = 0; m_last = NT - 1; m_fixrun = 0;
    for (int i = 0; i < NS; i++) begin
      m_live[i] = i % NT;
      m_pend[i] = i % NT;
    end
    for (int k = 0; k < ND; k++) begin
      m_tv[k] = 0;
      m_tt[k] = 0;
    end
  endtask

  // One clock: inputs are already set at a falling edge.
  task automatic cyc();
    int ev, et, owner, pol, tvexp, ttexp, clash;
    string req;
    #5;
    pol = int'(policy);
    ev = 0; et = 0;
    if (pol == 2) begin
      req = "R6";
      for (int k = 1; k <= NT; k++) begin
        int t;
        t = (m_last + k) % NT;
        if (ev == 0 && thr_ready[t]) begin
          ev = 1; et = t;
        end
      end
    end else begin
      owner = (pol == 1) ? m_live[m_slot] : m_rot;
      req = (pol == 1) ? "R4" : ((pol == 3) ? "R9" : "R2");
      if (thr_ready[owner]) begin
        ev = 1; et = owner;
      end else begin
        req = "R3";
      end
    end
    chk(req, int'(issue_valid), ev);
    chk(req, int'(issue_tid), et);
    chk("R3 bubble flag", int'(bubble), 1 - ev);
    tvexp = 0; ttexp = 0;
    for (int k = 0; k < ND; k++) begin
      tvexp = tvexp | (m_tv[k] << k);
      ttexp = ttexp | (m_tt[k] << (TW * k));
    end
    chk("R7 tag valid", int'(tag_valid), tvexp);
    chk("R7 tag tid", int'(tag_tid), ttexp);
    if (m_fixrun >= ND) begin
      clash = 0;
      for (int i = 0; i < ND; i++)
        for (int j = i + 1; j < ND; j++)
          if (j - i < NT && tag_valid[i] && tag_valid[j] &&
              tag_tid[i*TW +: TW] == tag_tid[j*TW +: TW]) clash = 1;
      chk("R8 spacing", clash, 0);
    end
    if (want_tid >= 0) begin
      chk(want_req, int'(issue_tid), want_tid);
      want_tid = -1;
    end
    // Advance the model to the next cycle.
    if (pol == 2 && ev == 1) m_last = et;
    if (tbl_wr_en) m_pend[int'(tbl_wr_slot)] = int'(tbl_wr_tid);
    if (m_slot == NS - 1)
      for (int i = 0; i < NS; i++) m_live[i] = m_pend[i];
    m_rot  = (m_rot + 1) % NT;
    m_slot = (m_slot + 1) % NS;
    for (int k = ND - 1; k > 0; k--) begin
      m_tv[k] = m_tv[k-1];
      m_tt[k] = m_tt[k-1];
    end
    m_tv[0] = ev;
    m_tt[0] = et;
    m_fixrun = (pol == 0 || pol == 3) ? m_fixrun + 1 : 0;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic shuffle_ready();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    thr_ready = lfsr[NT-1:0];
  endtask

  task automatic run_to_slot(input int s);
    while (m_slot != s) cyc();
  endtask

  task automatic tbl_write(input int slot, input int tid);
    tbl_wr_en = 1'b1;
    tbl_wr_slot = SW'(slot);
    tbl_wr_tid = TW'(tid);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    #5;
    chk("R1 tags invalid after reset", int'(tag_valid), 0);
    chk("R1 tag ids zero after reset", int'(tag_tid), 0);
    #0;
    @(negedge clk);
    // Reset aligned the model to the edge that followed release.
    model_reset();
    m_rot = 1; m_slot = 1;
    // Restart cleanly instead: reset once more and sample at release.
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();

    // R1/R2: fixed rotation, all ready, first owner is thread 0.
    policy = 2'd0; thr_ready = '1;
    want_tid = 0; want_req = "R1 first owner";
    for (int i = 0; i < 12; i++) cyc();

    // R3: thread 2 never ready in fixed rotation.
    thr_ready = 4'b1011;
    for (int i = 0; i < 12; i++) cyc();

    // R2/R3/R8: mixed ready patterns.
    for (int i = 0; i < 16; i++) begin
      shuffle_ready();
      cyc();
    end

    // R4: default table walk.
    policy = 2'd1; thr_ready = '1;
    for (int i = 0; i < 10; i++) cyc();

    // R5: mid-pass write to slot 5 stays hidden until the next pass.
    run_to_slot(3);
    tbl_write(5, 2);
    cyc();
    run_to_slot(5);
    want_tid = 1; want_req = "R5 old entry kept in current pass";
    cyc();
    // R5: write during slot S-1 applies to the following slot 0.
    run_to_slot(NS - 1);
    tbl_write(0, 3);
    cyc();
    want_tid = 3; want_req = "R5 write on last slot applies at slot 0";
    cyc();
    run_to_slot(5);
    want_tid = 2; want_req = "R5 mid-pass write visible next pass";
    cyc();

    // R3 in table mode: thread 3 not ready while it owns slots.
    thr_ready = 4'b0111;
    for (int i = 0; i < 10; i++) cyc();
    for (int i = 0; i < 12; i++) begin
      shuffle_ready();
      cyc();
    end

    // R6: ready-priority; first pick after reset starts at thread 0.
    policy = 2'd2; thr_ready = '1;
    want_tid = 0; want_req = "R1 first priority pick";
    cyc();
    for (int i = 0; i < 6; i++) cyc();
    thr_ready = 4'b0000;
    cyc();
    chk("R6 no ready gives bubble", int'(bubble), 1);
    thr_ready = 4'b1010;
    for (int i = 0; i < 4; i++) cyc();
    for (int i = 0; i < 20; i++) begin
      shuffle_ready();
      cyc();
    end

    // R9: code 3 follows the free-running rotation.
    policy = 2'd3; thr_ready = '1;
    want_tid = m_rot; want_req = "R9 alias keeps rotation position";
    for (int i = 0; i < 10; i++) cyc();
    for (int i = 0; i < 10; i++) begin
      shuffle_ready();
      cyc();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule